// File: doc/BRIEF.md
# Burst-Mode Handshake Controller

This block is a clocked, oversampled stand-in for a four-state burst-mode handshake controller. It watches three asynchronous request lines, a, b and c, and drives two acknowledge lines, x and y. In each state it waits for one input burst, which is a set of input edges that may arrive in any order. Once the last edge of the burst has been observed, it moves to the next state. The acknowledge pattern changes in the same clock edge as the state. Some inputs are directed don't-cares in a given state: they may move early without firing anything, and the next state takes their level into account when it is entered.

The states and arcs are as follows. REST (xy=00) goes to ARM on a rising, with b a don't-care. ARM (xy=11) goes to PEAK on b rising and c rising, in any order. PEAK (xy=01) goes to FALL on c falling. FALL (xy=10) goes back to REST on a falling and b falling, in any order. The inputs pass through a synchronizer before the burst logic sees them. A partly completed burst is tracked in per-input seen bits. Any edge that is not allowed in the current state raises a sticky error flag.

Top module: `burst_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the machine is in REST with dout={x,y}=00 and err=0. The input vector is din={c,b,a}, so bit 0 is a and bit 2 is c.
- R2: In REST, a rising moves the machine to ARM with dout=11. In REST, a change on b alone leaves dout=00 and err=0.
- R3: In ARM, the move to PEAK (dout=01) happens only after both b and c have risen, in either order. After only one of them has risen, dout stays 11.
- R4: In PEAK, c falling moves the machine to FALL with dout=10.
- R5: In FALL, the return to REST (dout=00) happens only after both a and b have fallen, in either order.
- R6: An input change reaches dout on the third rising clock edge after it is applied (two synchronizer stages plus the state register). It is not visible on the second edge.
- R7: Any edge on an input that is neither in the current burst nor a don't-care sets err. In the cycle where such an edge is detected, the state does not change, even if the burst completes in that same cycle. The completed burst then fires one cycle later.
- R8: When ARM is entered, a b that already rose early counts as seen. In that case c rising alone is enough to reach PEAK.
- R9: A burst input that returns to its old level before its burst has completed sets err, and the state is kept.
- R10: err stays at 1 once set, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 3 | Asynchronous request lines {c,b,a} |
| dout | output | 2 | Acknowledge lines {x,y} |
| err | output | 1 | Sticky illegal-edge flag |

## Verification
Burst completion and illegal-edge detection can fall in the same clock cycle. This happens when the last edge of a burst arrives together with a forbidden edge. The bench provokes this in ARM by raising c together with a falling. It then samples dout and err one edge apart. On the third edge, err must be 1 while dout still shows 11. On the fourth edge, dout must show 01. Random vectors that mix legal progress, don't-care edges and arbitrary patterns produce further collisions, and these are judged against a bench model that works on input levels only.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int NIN  = 3;   // {c,b,a}
    localparam int NOUT = 2;   // {x,y}

    typedef enum logic [1:0] {
        ST_REST = 2'd0,
        ST_ARM  = 2'd1,
        ST_PEAK = 2'd2,
        ST_FALL = 2'd3
    } st_t;

    typedef struct packed {
        logic [NIN-1:0] burst;  // inputs that make up the awaited burst
        logic [NIN-1:0] dc;     // directed don't-care inputs
        logic [NIN-1:0] tgt;    // level each burst input must reach
        st_t            nxt;    // state entered when the burst completes
    } arc_t;

    function automatic arc_t arc_of(st_t s);
        arc_t r;
        unique case (s)
            ST_REST: r = '{burst: 3'b001, dc: 3'b010, tgt: 3'b001, nxt: ST_ARM};
            ST_ARM:  r = '{burst: 3'b110, dc: 3'b000, tgt: 3'b110, nxt: ST_PEAK};
            ST_PEAK: r = '{burst: 3'b100, dc: 3'b000, tgt: 3'b000, nxt: ST_FALL};
            ST_FALL: r = '{burst: 3'b011, dc: 3'b000, tgt: 3'b000, nxt: ST_REST};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/burst_sync.sv
module burst_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/burst_track.sv
module burst_track #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,        // synchronized input levels
    input  logic [W-1:0] burst,      // current state's burst set
    input  logic [W-1:0] dc,         // current state's don't-care set
    input  logic [W-1:0] nxt_burst,  // burst set of the following state
    input  logic [W-1:0] nxt_tgt,    // target levels of the following state
    output logic [W-1:0] chg,
    output logic [W-1:0] seen,
    output logic         illegal,
    output logic         fire
);

    logic [W-1:0] prv_q;
    logic [W-1:0] seen_q;
    logic [W-1:0] seen_upd;
    logic [W-1:0] seen_d;
    logic         stray;
    logic         reversal;

    assign chg      = lvl ^ prv_q;
    // a burst edge on an unseen input reaches target; on a seen one it backs out
    assign seen_upd = (seen_q ^ (chg & burst)) & burst;
    assign stray    = |(chg & ~(burst | dc));
    assign reversal = |(chg & burst & seen_q);
    assign illegal  = stray | reversal;
    assign fire     = !illegal && (seen_upd == burst);

    // on entry the next state credits inputs already sitting at their target
    assign seen_d = fire ? (nxt_burst & ~(lvl ^ nxt_tgt)) : seen_upd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_q  <= '0;
            seen_q <= '0;
        end else begin
            prv_q  <= lvl;
            seen_q <= seen_d;
        end
    end

    assign seen = seen_q;

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIN-1:0]  din,
    output logic [NOUT-1:0] dout,
    output logic            err
);

    st_t            state_q;
    arc_t           cur;
    arc_t           nxt_arc;
    logic [NIN-1:0] lvl;
    logic [NIN-1:0] chg;
    logic [NIN-1:0] seen;
    logic           illegal;
    logic           fire;
    logic           err_q;

    burst_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (din),
        .q     (lvl)
    );

    assign cur     = arc_of(state_q);
    assign nxt_arc = arc_of(cur.nxt);

    burst_track #(.W(NIN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .burst     (cur.burst),
        .dc        (cur.dc),
        .nxt_burst (nxt_arc.burst),
        .nxt_tgt   (nxt_arc.tgt),
        .chg       (chg),
        .seen      (seen),
        .illegal   (illegal),
        .fire      (fire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= ST_REST;
        else if (fire) state_q <= cur.nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (illegal) err_q <= 1'b1;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_REST: dout = 2'b00;
            ST_ARM:  dout = 2'b11;
            ST_PEAK: dout = 2'b01;
            ST_FALL: dout = 2'b10;
        endcase
    end

    assign err = err_q;

endmodule

// File: rtl/burst_ctrl_chk.sv
module burst_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state,
    input logic [2:0] seen,
    input logic [2:0] burst,
    input logic [2:0] dc,
    input logic [2:0] chg,
    input logic       illegal,
    input logic       fire,
    input logic       err
);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R10

    AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> err); // R7

    AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(state)); // R7

    AST_FIRE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state != $past(state))); // R4

    AST_NO_EARLY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(state)); // R3

    AST_SEEN_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (seen & ~burst) == 3'b000); // R8

    AST_DC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != 3'b000 && (chg & ~dc) == 3'b000 && !err) |=> !err); // R2

endmodule

bind burst_ctrl burst_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .seen    (seen),
    .burst   (cur.burst),
    .dc      (cur.dc),
    .chg     (chg),
    .illegal (illegal),
    .fire    (fire),
    .err     (err)
);

// File: tb/burst_ctrl_test.sv
module burst_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] din = 3'b000;
    logic [1:0] dout;
    logic       err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model: state number, last applied levels, sticky flag
    int       m_st;
    logic [2:0] m_lvl;
    logic       m_err;

    always #10 clk = ~clk;  // 50 MHz

    burst_ctrl uut (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .dout  (dout),
        .err   (err)
    );

    function automatic logic [2:0] m_burst(int s);
        case (s) 0: return 3'b001; 1: return 3'b110; 2: return 3'b100; default: return 3'b011; endcase
    endfunction
    function automatic logic [2:0] m_dc(int s);
        return (s == 0) ? 3'b010 : 3'b000;
    endfunction
    function automatic logic [2:0] m_tgt(int s);
        case (s) 0: return 3'b001; 1: return 3'b110; default: return 3'b000; endcase
    endfunction
    function automatic logic [1:0] m_out(int s);
        case (s) 0: return 2'b00; 1: return 2'b11; 2: return 2'b01; default: return 2'b10; endcase
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic model_step(logic [2:0] v);
        logic [2:0] ch;
        logic [2:0] bm;
        ch = v ^ m_lvl;
        bm = m_burst(m_st);
        if ((ch & ~(bm | m_dc(m_st))) != 3'b000 ||
            (ch & bm & ~(m_lvl ^ m_tgt(m_st))) != 3'b000)
            m_err = 1'b1;
        m_lvl = v;
        for (int k = 0; k < 4; k++) begin
            if (((m_lvl ^ m_tgt(m_st)) & m_burst(m_st)) == 3'b000)
                m_st = (m_st + 1) % 4;
            else
                break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din   = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st  = 0;
        m_lvl = 3'b000;
        m_err = 1'b0;
        @(negedge clk);
        check("R1 reset", {dout, err, 1'b0}, 4'b0000);
    endtask

    task automatic apply(logic [2:0] v, string tag);
        @(negedge clk);
        din = v;
        repeat (9) @(negedge clk);
        model_step(v);
        check(tag, {dout, err, 1'b0}, {m_out(m_st), m_err, 1'b0});
    endtask

    // two-stage view: value after edge 2, value after edge 3 and 4
    task automatic apply_timed(logic [2:0] v, string tag,
                               logic [2:0] e2, logic [2:0] e3, logic [2:0] e4);
        @(negedge clk);
        din = v;
        repeat (2) @(negedge clk);
        check({tag, " edge2"}, {dout, err, 1'b0}, {e2, 1'b0});
        @(negedge clk);
        check({tag, " edge3"}, {dout, err, 1'b0}, {e3, 1'b0});
        @(negedge clk);
        check({tag, " edge4"}, {dout, err, 1'b0}, {e4, 1'b0});
        repeat (6) @(negedge clk);
        model_step(v);
    endtask

    initial begin
        void'($urandom(32'd552));
        do_reset();

        // R2 / R8: b early as don't-care, then a, then only c
        apply(3'b010, "R2 dc b rises in REST");
        check("R2 still REST", {dout, err, 1'b0}, 4'b0000);
        apply(3'b011, "R2 a rises");
        check("R2 ARM", {dout, err, 1'b0}, 4'b1100);
        apply(3'b111, "R8 c alone completes");
        check("R8 PEAK", {dout, err, 1'b0}, 4'b0100);

        // R3 c before b, R4, R5 b before a
        do_reset();
        apply(3'b001, "R2 a rises");
        apply(3'b101, "R3 c first");
        check("R3 hold ARM", {dout, err, 1'b0}, 4'b1100);
        apply(3'b111, "R3 b completes");
        check("R3 PEAK", {dout, err, 1'b0}, 4'b0100);
        apply(3'b011, "R4 c falls");
        check("R4 FALL", {dout, err, 1'b0}, 4'b1000);
        apply(3'b001, "R5 b first");
        check("R5 hold FALL", {dout, err, 1'b0}, 4'b1000);
        apply(3'b000, "R5 a completes");
        check("R5 REST", {dout, err, 1'b0}, 4'b0000);

        // R6 latency
        apply_timed(3'b001, "R6 latency", 3'b000, 3'b110, 3'b110);

        // R9 reversal, then R10 stickiness
        do_reset();
        apply(3'b001, "R2 a rises");
        apply(3'b011, "R9 b rises");
        apply(3'b001, "R9 b backs out");
        check("R9 err held ARM", {dout, err, 1'b0}, 4'b1110);
        apply(3'b101, "R10 c rises");
        apply(3'b111, "R10 b completes");
        check("R10 err stays", {dout, err, 1'b0}, 4'b0110);
        do_reset();

        // R7 stray edge alone, then stray edge colliding with completion
        apply(3'b100, "R7 stray c in REST");
        check("R7 REST flagged", {dout, err, 1'b0}, 4'b0010);
        do_reset();
        apply(3'b001, "R2 a rises");
        apply(3'b011, "R7 b rises");
        apply_timed(3'b110, "R7 collision", 3'b110, 3'b111, 3'b011);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] v;
            int r;
            if (n % 50 == 0) do_reset();
            r = $urandom % 10;
            if (r < 7) begin
                v = m_lvl ^ (m_burst(m_st) & 3'($urandom % 8));
                if (v == m_lvl) v = m_lvl ^ m_burst(m_st);
            end else if (r < 9) begin
                v = m_lvl ^ m_dc(m_st);
            end else begin
                v = 3'($urandom % 8);
            end
            apply(v, "R7 random vs model");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule